// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator Peripheral

A register-mapped random word source for a simple 32-bit word-access bus. Software loads five seed words, selects generator mode and writes a start bit into the control register. The block keeps track of which seed words have been written. It launches a run only when all five are loaded, the mode bit is set and the engine is idle. A run copies the seeds into a 160-bit xorshift state and steps the state for a fixed number of cycles. It then publishes five fresh output words at once and raises a completion flag. Software polls the status register for that flag and clears it by writing to status.

The control register keeps whatever was written, except that the start bit always reads back as 0. In the status register, buffer-ready is fixed at 1 and seed-complete and busy are derived from internal state. The three completion flags can be written by software.

Top module: `prng_periph`

## Requirements
- R1: After reset, control reads 0x0, status reads 0x1, every output word reads 0 and no seed word counts as written.
- R2: Register map, all accesses 32-bit at byte offsets: control 0x000, status 0x010, seed word n at 0x140+4n, output word n at 0x160+4n (n = 0..4). Reads of seed words, of unmapped or misaligned offsets, or with no read in progress return 0. Writes to unmapped offsets change nothing.
- R3: A write to seed word n marks seed n as written. Status bit 1 is 1 exactly when all five seeds are marked. Marks clear only on reset.
- R4: A control write stores the written value, and bit 4 (start) always reads back as 0.
- R5: A control write starts a run only if status bit 1 is already 1, the written value has bit 3 (mode) and bit 4 (start) set, and no run is in progress.
- R6: Status bit 2 (busy) is 1 for exactly RUN_CYCLES (default 8) cycles after the clock edge of the starting write.
- R7: A run loads state words s0..s4 from seed words 0..4. Each cycle it steps t = s0 ^ (s0 >> 2), shifts s1..s4 into s0..s3 and sets the new s4 = s4 ^ (s4 << 4) ^ t ^ (t << 1). After RUN_CYCLES steps, output word n equals sn.
- R8: All five output words change on the same edge that sets status bit 5 (done). At no other time do they change.
- R9: A status write updates only bits 3, 4 and 5, taking them from the written value. If a run completes on the same edge, bit 5 is still set.
- R10: A start request while busy is ignored apart from being stored with bit 4 cleared. The current run keeps its timing.
- R11: Status bit 0 always reads 1, and bits 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address inside the 0x200 window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address and state |

## Verification
The assertions assume at most one bus access per cycle and a stable address and data during that cycle. They also assume a run is requested only through a control write. The bench drives every access for exactly one cycle from the falling edge, so each write is seen by exactly one rising edge. When idle it keeps reading status, which makes busy and the flags visible on every cycle. It times a status write to land on the completion edge, and it issues a second start while a run is in progress to exercise the priority and ignore cases.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int unsigned OFF_CTRL = 'h000;
  localparam int unsigned OFF_STAT = 'h010;
  localparam int unsigned OFF_SEED = 'h140;
  localparam int unsigned OFF_OUT  = 'h160;

  localparam int unsigned CTRL_MODE_BIT  = 3;
  localparam int unsigned CTRL_START_BIT = 4;
  localparam int unsigned STAT_DONE_BIT  = 5;
endpackage

// File: rtl/prng_regs.sv
module prng_regs #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               ctrl_we_i,
  input  logic                               stat_we_i,
  input  logic [NUM_WORDS-1:0]               seed_we_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic                               busy_i,
  input  logic                               done_i,
  output logic [DATA_W-1:0]                  ctrl_o,
  output logic [DATA_W-1:0]                  status_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]   seeds_o,
  output logic                               start_o
);
  import prng_pkg::*;

  logic [DATA_W-1:0]    ctrl_q;
  logic [2:0]           flags_q;
  logic [NUM_WORDS-1:0] mask_q;
  logic                 seed_done;
  logic [2:0]           flags_d;

  assign seed_done = &mask_q;
  assign start_o   = ctrl_we_i && wdata_i[CTRL_MODE_BIT] && wdata_i[CTRL_START_BIT]
                     && seed_done && !busy_i;

  always_comb begin
    flags_d = flags_q;
    if (stat_we_i) flags_d = wdata_i[5:3];
    if (done_i)    flags_d[2] = 1'b1;  // completion wins over a clearing write
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
      if (ctrl_we_i) begin
        ctrl_q                 <= wdata_i;
        ctrl_q[CTRL_START_BIT] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_seed
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seeds_o[i] <= '0;
        mask_q[i]  <= 1'b0;
      end else if (seed_we_i[i]) begin
        seeds_o[i] <= wdata_i;
        mask_q[i]  <= 1'b1;
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = DATA_W'({1'b0, 1'b0, flags_q, busy_i, seed_done, 1'b1});

  p_seed_done_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> $past(|seed_we_i));
  p_done_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> status_o[STAT_DONE_BIT]);
  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_we_i && !done_i) |=> $stable(status_o[5:3]));
  p_no_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_o);
endmodule

// File: rtl/prng_core.sv
module prng_core #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_WORDS  = 5,
  parameter int unsigned RUN_CYCLES = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0]  seeds_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words_o
);
  localparam int unsigned CNT_W = $clog2(RUN_CYCLES + 1);
  typedef logic [NUM_WORDS-1:0][DATA_W-1:0] state_t;

  state_t           st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] t;

  always_comb begin
    t = st_q[0] ^ (st_q[0] >> 2);
    for (int i = 0; i < NUM_WORDS - 1; i++) st_nxt[i] = st_q[i+1];
    st_nxt[NUM_WORDS-1] = st_q[NUM_WORDS-1] ^ (st_q[NUM_WORDS-1] << 4) ^ t ^ (t << 1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      cnt_q   <= '0;
      words_o <= '0;
    end else if (start_i) begin
      st_q  <= seeds_i;
      cnt_q <= CNT_W'(RUN_CYCLES);
    end else if (busy_o) begin
      st_q  <= st_nxt;
      cnt_q <= cnt_q - CNT_W'(1);
      if (done_o) words_o <= st_nxt;  // whole set at once
    end
  end

  p_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_done_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_words_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(words_o));
endmodule

// File: rtl/prng_periph.sv
module prng_periph #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_WORDS  = 5,
  parameter int unsigned RUN_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  import prng_pkg::*;

  logic hit_ctrl, hit_stat, wr, rd;
  logic [NUM_WORDS-1:0] hit_seed, hit_out, seed_we;
  logic [DATA_W-1:0] ctrl, status;
  logic [NUM_WORDS-1:0][DATA_W-1:0] seeds, words;
  logic start, busy, done;

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign hit_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign hit_stat = (addr_i == ADDR_W'(OFF_STAT));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_dec
    assign hit_seed[i] = (addr_i == ADDR_W'(OFF_SEED + 4 * i));
    assign hit_out[i]  = (addr_i == ADDR_W'(OFF_OUT + 4 * i));
    assign seed_we[i]  = wr && hit_seed[i];
  end

  prng_regs #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(wr && hit_ctrl),
    .stat_we_i(wr && hit_stat),
    .seed_we_i(seed_we),
    .wdata_i  (wdata_i),
    .busy_i   (busy),
    .done_i   (done),
    .ctrl_o   (ctrl),
    .status_o (status),
    .seeds_o  (seeds),
    .start_o  (start)
  );

  prng_core #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .RUN_CYCLES(RUN_CYCLES)) core_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .seeds_i(seeds),
    .busy_o (busy),
    .done_o (done),
    .words_o(words)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit_ctrl) rdata_o = ctrl;
      if (hit_stat) rdata_o = status;
      for (int i = 0; i < NUM_WORDS; i++) if (hit_out[i]) rdata_o = words[i];
    end
  end

  p_unmapped_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !hit_ctrl && !hit_stat && !(|hit_out)) |-> (rdata_o == '0));
  p_status_fixed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_stat) |-> (rdata_o[0] && !rdata_o[6] && !rdata_o[7]));
  p_start_readback_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_ctrl) |-> !rdata_o[CTRL_START_BIT]);
endmodule

// File: tb/prng_periph_tb.sv
module prng_periph_tb_top;
  localparam int N   = 5;
  localparam int RUN = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        b_req = 1'b0, b_we = 1'b0;
  logic [8:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  prng_periph dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(b_req), .we_i(b_we),
    .addr_i(b_addr), .wdata_i(b_wdata), .rdata_o(rdata)
  );

  // behavioural reference model
  logic [31:0] m_ctrl, m_seed[N], m_st[N], m_out[N];
  logic [4:0]  m_mask;
  logic [2:0]  m_flags;
  int          m_cnt;

  task automatic xs_step();
    logic [31:0] t, nv;
    t  = m_st[0] ^ (m_st[0] >> 2);
    nv = m_st[4] ^ (m_st[4] << 4) ^ t ^ (t << 1);
    for (int i = 0; i < N - 1; i++) m_st[i] = m_st[i+1];
    m_st[4] = nv;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_mask = 0; m_flags = 0; m_cnt = 0;
      for (int i = 0; i < N; i++) begin m_seed[i] = 0; m_st[i] = 0; m_out[i] = 0; end
    end else begin
      bit was_busy, fin;
      was_busy = (m_cnt != 0);
      fin = 0;
      if (was_busy) begin
        xs_step();
        m_cnt--;
        if (m_cnt == 0) begin
          for (int i = 0; i < N; i++) m_out[i] = m_st[i];
          fin = 1;
        end
      end
      if (b_req && b_we) begin
        if (b_addr == 9'h000) begin
          m_ctrl = b_wdata & ~32'h10;
          if (b_wdata[3] && b_wdata[4] && m_mask == 5'h1f && !was_busy) begin
            for (int i = 0; i < N; i++) m_st[i] = m_seed[i];
            m_cnt = RUN;
          end
        end else if (b_addr == 9'h010) begin
          m_flags = b_wdata[5:3];
        end else begin
          for (int i = 0; i < N; i++)
            if (b_addr == 9'(32'h140 + 4 * i)) begin
              m_seed[i] = b_wdata; m_mask[i] = 1'b1;
            end
        end
      end
      if (fin) m_flags[2] = 1'b1;
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] v;
    v = 0;
    if (b_req && !b_we) begin
      if (b_addr == 9'h000) v = m_ctrl;
      else if (b_addr == 9'h010) v = {24'b0, 2'b0, m_flags, m_cnt != 0, m_mask == 5'h1f, 1'b1};
      else for (int i = 0; i < N; i++) if (b_addr == 9'(32'h160 + 4 * i)) v = m_out[i];
    end
    return v;
  endfunction

  function automatic string addr_tag();
    if (b_addr == 9'h000) return "R4";
    if (b_addr == 9'h010) return "R6";
    if (b_addr >= 9'h160 && b_addr < 9'h174 && b_addr[1:0] == 2'b00) return "R7";
    return "R2";
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, b_addr, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_ni) check({addr_tag(), " model"}, rdata, exp_rd());
  end

  task automatic op(bit we, logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    b_req = 1'b1; b_we = we; b_addr = a; b_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(1'b0, 9'h010, 0);
  endtask

  task automatic rd_chk(string tag, logic [8:0] a, logic [31:0] exp);
    op(1'b0, a, 0);
    #1 check(tag, rdata, exp);
  endtask

  function automatic logic [31:0] ref_word(logic [31:0] s[N], int k);
    logic [31:0] w[N], t, nv;
    for (int i = 0; i < N; i++) w[i] = s[i];
    for (int r = 0; r < RUN; r++) begin
      t  = w[0] ^ (w[0] >> 2);
      nv = w[4] ^ (w[4] << 4) ^ t ^ (t << 1);
      for (int i = 0; i < N - 1; i++) w[i] = w[i+1];
      w[4] = nv;
    end
    return w[k];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic [31:0] seeds[N] = '{32'h1234_5678, 32'h9abc_def0, 32'h0f0f_1e1e, 32'hdead_beef, 32'h0000_0001};
  logic [31:0] prev0;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    rd_chk("R1 ctrl reset", 9'h000, 32'h0);
    rd_chk("R1 status reset", 9'h010, 32'h1);
    rd_chk("R1 out0 reset", 9'h160, 32'h0);
    rd_chk("R1 out4 reset", 9'h170, 32'h0);

    op(1'b1, 9'h000, 32'h18);
    rd_chk("R5 no run without seeds", 9'h010, 32'h1);
    rd_chk("R4 start cleared", 9'h000, 32'h08);

    for (int i = 0; i < 4; i++) op(1'b1, 9'(32'h140 + 4 * i), seeds[i]);
    rd_chk("R3 partial seeds", 9'h010, 32'h1);
    op(1'b1, 9'h150, seeds[4]);
    rd_chk("R3 all seeds", 9'h010, 32'h3);
    rd_chk("R2 seed not readable", 9'h140, 32'h0);

    op(1'b1, 9'h000, 32'h10);
    rd_chk("R5 no run without mode", 9'h010, 32'h3);

    op(1'b1, 9'h000, 32'h1c);
    for (int i = 0; i < RUN; i++) rd_chk("R6 busy window", 9'h010, 32'h7);
    rd_chk("R8 done after run", 9'h010, 32'h23);
    rd_chk("R4 stored value", 9'h000, 32'h0c);
    for (int k = 0; k < N; k++)
      rd_chk("R7 output word", 9'(32'h160 + 4 * k), ref_word(seeds, k));

    op(1'b1, 9'h010, 32'hff);
    rd_chk("R9 R11 status write ones", 9'h010, 32'h3b);
    op(1'b1, 9'h010, 32'h0);
    rd_chk("R9 status clear", 9'h010, 32'h3);

    op(1'b1, 9'h0a0, 32'hffff_ffff);
    rd_chk("R2 unmapped read", 9'h0a0, 32'h0);
    rd_chk("R2 misaligned read", 9'h161, 32'h0);
    rd_chk("R2 unmapped write no effect", 9'h010, 32'h3);

    // second run: restart attempt while busy, clear landing on completion edge
    seeds[0] = 32'hcafe_f00d;
    op(1'b1, 9'h140, seeds[0]);
    op(1'b0, 9'h160, 0);
    #1 prev0 = rdata;
    op(1'b1, 9'h000, 32'h18);
    idle(1);
    op(1'b1, 9'h000, 32'h18);
    rd_chk("R10 restart ignored", 9'h000, 32'h08);
    idle(RUN - 4);
    op(1'b1, 9'h010, 32'h0);
    rd_chk("R9 R8 done wins over clear", 9'h010, 32'h23);
    rd_chk("R7 second run word0", 9'h160, ref_word(seeds, 0));
    n_chk++;
    if (ref_word(seeds, 0) == prev0) begin
      n_fail++; $display("FAIL R7 outputs unchanged got=%h exp!=%h", ref_word(seeds, 0), prev0);
    end
    rd_chk("R10 no extra run", 9'h010, 32'h23);

    @(negedge clk);
    b_req = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd_chk("R3 R1 marks cleared by reset", 9'h010, 32'h1);
    rd_chk("R1 outputs cleared", 9'h16c, 32'h0);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule